// File: doc/BRIEF.md
# SHA-512 Dual-Lane Hash Step Unit

This datapath performs the first half of two consecutive SHA-512 compression rounds in a single operation. It takes three 128-bit operands: an accumulator `acc_w` that is later overwritten, a first source `src_x` and a second source `src_y`. Each operand holds two 64-bit lanes. Lane 0 is bits 63:0 and lane 1 is bits 127:64.

The upper lane forms `U = Ch(Y1, X0, X1) + S1(Y1) + W1`. That sum plus `Y0` gives a chaining value `T`. The lower lane then forms `L = Ch(T, Y1, X0) + S1(T) + W0`. The two rounds therefore depend on each other in series within one operation. Here `S1(v)` is the XOR of `v` rotated right by 14, by 18 and by 41. `Ch(a,b,c)` is `(a & b) ^ (~a & c)`.

The unit also decodes the three register indices of the 32-bit instruction word and flags whether the word carries this operation's fixed opcode bits. A write-back stage takes the registered 128-bit result `{U, L}` one cycle after `op_valid`.

Top module: `sha512_dual_round`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `res_valid` is 0 after that edge, even if `op_valid` is high.
- R2: `res_valid` is 1 in the cycle after each edge that samples `op_valid` high, and 0 in the cycle after each edge that samples it low. Operations may be issued on every cycle.
- R3: After an edge that samples `op_valid` low, `result`, the three index outputs and `op_legal` keep their previous values.
- R4: `dst_idx` is instruction bits 4:0, `src1_idx` is bits 9:5 and `src2_idx` is bits 20:16, each taken from the instruction sampled with `op_valid`.
- R5: `op_legal` is 1 exactly when instruction bits 31:21 equal 11001110011 and bits 15:10 equal 100000.
- R6: The rotation function S1 rotates right by 14, 18 and 41 and XORs the three results. This is checked by sweeping a single set bit through every position of Y1.
- R7: The choose function selects each bit of its second argument where the first argument is 1, and of its third argument where it is 0.
- R8: `result[127:64]` equals `Ch(Y1,X0,X1) + S1(Y1) + W1` modulo 2^64.
- R9: `result[63:0]` equals `Ch(T,Y1,X0) + S1(T) + W0` modulo 2^64, where `T = result[127:64] + Y0` modulo 2^64. No carry passes between the two lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request, sampled at each rising edge |
| insn | input | 32 | Instruction word |
| acc_w | input | 128 | Accumulator operand W |
| src_x | input | 128 | First source operand X |
| src_y | input | 128 | Second source operand Y |
| res_valid | output | 1 | Result valid, one cycle after a request |
| result | output | 128 | New accumulator value {upper lane, lower lane} |
| dst_idx | output | 5 | Destination register index |
| src1_idx | output | 5 | First-source register index |
| src2_idx | output | 5 | Second-source register index |
| op_legal | output | 1 | Instruction matches the fixed opcode bits |

## Verification
Two events can fall in the same cycle. One is the presentation of a finished result with its valid flag. The other is the capture of the next operand set, which overwrites that same output register at the coming edge. The bench issues long runs of operations on consecutive cycles. At each falling edge it compares the outputs of the previous operation against its own arithmetic model, and only then drives the next operation. A capture that came one cycle early, or a valid flag that was lost, therefore shows up as a mismatch. Idle gaps after these bursts confirm that the valid flag drops and the held result stays unchanged.

// File: rtl/sha512_dual_round.sv
module sha512_dual_round #(
  parameter int LANE_W = 64,
  parameter int IDX_W  = 5,
  parameter int ROT_A  = 14,
  parameter int ROT_B  = 18,
  parameter int ROT_C  = 41
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [31:0]           insn,
  input  logic [2*LANE_W-1:0]   acc_w,
  input  logic [2*LANE_W-1:0]   src_x,
  input  logic [2*LANE_W-1:0]   src_y,
  output logic                  res_valid,
  output logic [2*LANE_W-1:0]   result,
  output logic [IDX_W-1:0]      dst_idx,
  output logic [IDX_W-1:0]      src1_idx,
  output logic [IDX_W-1:0]      src2_idx,
  output logic                  op_legal
);
  localparam int VEC_W = 2 * LANE_W;
  localparam int SRC1_LSB = IDX_W;
  localparam int SRC2_LSB = 16;

  typedef logic [LANE_W-1:0] lane_t;

  function automatic lane_t rotr(input lane_t v, input int s);
    return (v >> s) | (v << (LANE_W - s));
  endfunction

  function automatic lane_t big_sigma(input lane_t v);
    return rotr(v, ROT_A) ^ rotr(v, ROT_B) ^ rotr(v, ROT_C);
  endfunction

  function automatic lane_t choose(input lane_t a, input lane_t b, input lane_t c);
    return (a & b) ^ (~a & c);
  endfunction

  lane_t w0, w1, x0, x1, y0, y1;
  lane_t upper, chain, lower;
  logic  legal_d;

  assign {w1, w0} = acc_w;
  assign {x1, x0} = src_x;
  assign {y1, y0} = src_y;

  assign upper = choose(y1, x0, x1) + big_sigma(y1) + w1;
  assign chain = upper + y0;
  assign lower = choose(chain, y1, x0) + big_sigma(chain) + w0;

  assign legal_d = (insn[31:21] == 11'b11001110011) && (insn[15:10] == 6'b100000);

  always_ff @(posedge clk) begin
    if (!rst_n) res_valid <= 1'b0;
    else        res_valid <= op_valid;
  end

  always_ff @(posedge clk) begin
    if (op_valid) begin
      result   <= {upper, lower};
      dst_idx  <= insn[IDX_W-1:0];
      src1_idx <= insn[SRC1_LSB +: IDX_W];
      src2_idx <= insn[SRC2_LSB +: IDX_W];
      op_legal <= legal_d;
    end
  end

  p_reset_clears_r1: assert property (@(posedge clk) !rst_n |=> !res_valid);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  p_hold_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(result));
  p_dst_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> dst_idx == $past(insn[4:0]));
  p_upper_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> result[VEC_W-1:LANE_W] == $past(upper));
  p_lower_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> result[LANE_W-1:0] == $past(lower));
endmodule

// File: tb/sha512_dual_round_tb.sv
module sha512_dual_round_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] acc_w = '0, src_x = '0, src_y = '0;
  logic         res_valid;
  logic [127:0] result;
  logic [4:0]   dst_idx, src1_idx, src2_idx;
  logic         op_legal;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic         pend = 0;
  logic [127:0] exp_res;
  logic [4:0]   exp_d, exp_n, exp_m;
  logic         exp_legal;
  logic [127:0] last_res;

  always #10 clk = ~clk;

  sha512_dual_round u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .insn(insn),
    .acc_w(acc_w), .src_x(src_x), .src_y(src_y),
    .res_valid(res_valid), .result(result), .dst_idx(dst_idx),
    .src1_idx(src1_idx), .src2_idx(src2_idx), .op_legal(op_legal)
  );

  function automatic logic [63:0] m_rot(input logic [63:0] v, input int s);
    logic [127:0] d;
    d = {v, v} >> s;
    return d[63:0];
  endfunction

  function automatic logic [63:0] m_sig(input logic [63:0] v);
    return m_rot(v, 41) ^ m_rot(v, 14) ^ m_rot(v, 18);
  endfunction

  function automatic logic [63:0] m_ch(input logic [63:0] a, b, c);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = a[i] ? b[i] : c[i];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle_prev();
    if (pend) begin
      check(res_valid === 1'b1, "R2 valid", {127'b0, res_valid}, 128'd1);
      check(result[127:64] === exp_res[127:64], "R8 upper lane", {64'b0, result[127:64]}, {64'b0, exp_res[127:64]});
      check(result[63:0] === exp_res[63:0], "R9 lower lane", {64'b0, result[63:0]}, {64'b0, exp_res[63:0]});
      check({dst_idx, src1_idx, src2_idx} === {exp_d, exp_n, exp_m}, "R4 fields",
            {113'b0, dst_idx, src1_idx, src2_idx}, {113'b0, exp_d, exp_n, exp_m});
      check(op_legal === exp_legal, "R5 legal", {127'b0, op_legal}, {127'b0, exp_legal});
      last_res = result;
    end
  endtask

  task automatic issue(input logic [31:0] i, input logic [127:0] w, x, y);
    logic [63:0] u, t, l;
    @(negedge clk);
    settle_prev();
    insn = i; acc_w = w; src_x = x; src_y = y; op_valid = 1'b1;
    u = m_ch(y[127:64], x[63:0], x[127:64]) + m_sig(y[127:64]) + w[127:64];
    t = u + y[63:0];
    l = m_ch(t, y[127:64], x[63:0]) + m_sig(t) + w[63:0];
    exp_res = {u, l};
    exp_d = i[4:0]; exp_n = i[9:5]; exp_m = i[20:16];
    exp_legal = (i[31:21] == 11'h673) && (i[15:10] == 6'h20);
    pend = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pend) settle_prev();
      else begin
        check(res_valid === 1'b0, "R2 idle valid", {127'b0, res_valid}, 128'd0);
        check(result === last_res, "R3 hold", result, last_res);
      end
      op_valid = 1'b0;
      insn = $urandom; acc_w = {4{$urandom}}; src_x = {4{$urandom}}; src_y = {4{$urandom}};
      pend = 1'b0;
    end
  endtask

  function automatic logic [31:0] enc(input logic [4:0] m, n, d);
    return {11'b11001110011, m, 6'b100000, n, d};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    op_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(res_valid === 1'b0, "R1 reset", {127'b0, res_valid}, 128'd0);
    op_valid = 1'b0;
    rst_n = 1'b1;
    // first known result before idle hold checks
    issue(enc(5'd1, 5'd2, 5'd3), '0, '0, '0);
    issue(enc(5'd31, 5'd0, 5'd17), '1, '1, '1);
    idle(3);
    // R6: single bit walk through Y1; R7: choose with alternating masks
    for (int i = 0; i < 64; i++)
      issue(enc(i[4:0], ~i[4:0], i[5:1]), '0, '0, {64'd1 << i, 64'd0});
    for (int i = 0; i < 64; i++)
      issue(enc(5'd0, 5'd0, 5'd0), '0, {64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555},
            {64'd1 << i, 64'd1 << (63 - i)});
    idle(2);
    // R9 carry isolation: maximal lower lane sums
    issue(enc(5'd4, 5'd5, 5'd6), {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, '1, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF});
    // R5: corrupt each fixed bit
    for (int b = 0; b < 32; b++) begin
      logic [31:0] e;
      e = enc(5'd9, 5'd10, 5'd11);
      if (b >= 21 || (b >= 10 && b <= 15)) e[b] = ~e[b];
      issue(e, '0, '0, '0);
    end
    idle(2);
    for (int r = 0; r < 1200; r++) begin
      issue($urandom, {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom});
      if (r % 97 == 96) idle(2);
    end
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule